// File: doc/BRIEF.md
# Monte Carlo Path Packet Scheduler

This control unit keeps a fixed-latency path-update pipeline busy every clock cycle. The pipeline has no stall input: each cycle it takes one packet and, a fixed number of cycles later, hands one packet to an output FIFO. The FIFO is deeper than the pipeline latency. Each packet holds the state of one simulated path: price, volatility, step number and a knock-out flag (`ok`).

A path that crosses a barrier is not removed early. It keeps circulating with `ok` cleared. At each cycle the scheduler issues exactly one packet, which is one of three kinds:
- a freshly created path,
- a recirculated path taken from the FIFO head,
- a bubble, which has `live` low.

Every live issue carries a random pair. Pairs are shared antithetically: a pair is accepted from the random source and used as is for one issue, and its negation is used for the next issue. Finished paths retire by sending their payoff to the host over a valid/ready channel. A knocked-out path sends a payoff of zero.

States:
- `ST_FILL`: paths are created until `SLOTS` of them exist.
- `ST_RUN`: the FIFO head is served.

There is one transition, `ST_FILL -> ST_RUN`. It is taken on the cycle that creates the last of the `SLOTS` paths.

Per-cycle actions in `ST_RUN`:
- `ACT_RECIRC`: the head packet is sent back into the pipeline.
- `ACT_RETIRE`: the head packet is retired and a new path is created in its place.
- `ACT_BUBBLE`: nothing is served.

In `ST_FILL` the only actions are `ACT_CREATE` and `ACT_BUBBLE`. `SLOTS` must be larger than the pipeline latency and no larger than the FIFO depth. The FIFO stores only live packets; bubbles are dropped at the pipeline exit.

Top module: `mc_path_sched`

## Requirements
- R1: After reset the state is `ST_FILL`, no path has been created, and the random pair is unheld. `host_valid` is low. With no random pair available, the issue is a bubble, `fifo_pop` is low and `rnd_ready` is low.
- R2: Exactly one packet is issued every cycle. A bubble has `iss_live`=0, and all of its other issue fields are zero.
- R3: While fewer than `SLOTS` paths have been created, the scheduler does the following whenever a random value is available: it issues a live new path with step 0, price `INIT_PRICE`, volatility `INIT_VOL` and `iss_ok`=1. In this phase the FIFO is never popped.
- R4: No more than `SLOTS` paths are ever created by the fill phase. After that, a new path appears only as the replacement for a retired one.
- R5: In `ST_RUN`, when the FIFO head has step below `N_STEPS` and a random value is available, the head is popped. It is reissued in the same cycle with its step, price, volatility and ok flag unchanged.
- R6: In `ST_RUN`, when the FIFO head has step equal to `N_STEPS` and a random value is available, `host_valid` is 1. `host_payoff` is the head price when its ok flag is 1, and 0 otherwise. When `host_ready` is also 1, the head is popped and a new path is issued in the same cycle.
- R7: The first use of a pair asserts `rnd_ready` and issues `rnd_a`/`rnd_b` as given. The next use issues their two's-complement negations with `rnd_ready` low. So each accepted pair serves exactly two live issues.
- R8: When a required handshake is missing, the scheduler issues a bubble and does not pop. The missing handshake is either no random value, or, for a finished head, `host_ready` low.
- R9: Once `host_valid` is high while `host_ready` is low, `host_valid` stays high with an unchanged payoff in the next cycle.
- R10: In `ST_RUN` with an empty FIFO, a bubble is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rnd_valid | input | 1 | Random pair offered |
| rnd_ready | output | 1 | Random pair accepted |
| rnd_a | input | RND_W | Random value for price (signed) |
| rnd_b | input | RND_W | Random value for volatility (signed) |
| host_valid | output | 1 | Payoff offered to host |
| host_ready | input | 1 | Host accepts payoff |
| host_payoff | output | PRICE_W | Final price or zero |
| iss_live | output | 1 | Issued packet is a real path |
| iss_ok | output | 1 | Issued path not knocked out |
| iss_step | output | STEP_W | Issued step number |
| iss_price | output | PRICE_W | Issued price |
| iss_vol | output | VOL_W | Issued volatility |
| iss_rnd_a | output | RND_W | Random value for price with this issue |
| iss_rnd_b | output | RND_W | Random value for volatility with this issue |
| fifo_valid | input | 1 | FIFO holds a packet |
| fifo_pop | output | 1 | Pop FIFO head |
| fifo_ok | input | 1 | Head ok flag |
| fifo_step | input | STEP_W | Head step number |
| fifo_price | input | PRICE_W | Head price |
| fifo_vol | input | VOL_W | Head volatility |

## Verification
The bench builds the scheduler with `SLOTS`=6 and `N_STEPS`=3. Around it sit a four-stage stand-in pipeline and an eight-entry FIFO. The pipeline adds the price random value and knocks out paths that reach 130 from a start of 100. This small loop lets every path retire many times within a short run. Both knocked-out and surviving retirements occur. Every issue decision is compared cycle by cycle, across four phases that in turn starve the random source, stall the host, and do both.

// File: rtl/mc_sched_pkg.sv
package mc_sched_pkg;
    typedef enum logic [0:0] {ST_FILL, ST_RUN} sched_state_t;
    typedef enum logic [1:0] {ACT_BUBBLE, ACT_CREATE, ACT_RECIRC, ACT_RETIRE} sched_act_t;
endpackage

// File: rtl/mc_anti_pair.sv
module mc_anti_pair #(
    parameter int RND_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    rnd_valid,
    input  logic signed [RND_W-1:0] rnd_a,
    input  logic signed [RND_W-1:0] rnd_b,
    output logic                    avail,
    output logic                    rnd_ready,
    output logic signed [RND_W-1:0] use_a,
    output logic signed [RND_W-1:0] use_b
);
    logic                    half;
    logic signed [RND_W-1:0] held_a, held_b;

    assign avail     = half | rnd_valid;
    assign rnd_ready = take & ~half;
    assign use_a     = half ? -held_a : rnd_a;
    assign use_b     = half ? -held_b : rnd_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half   <= 1'b0;
            held_a <= '0;
            held_b <= '0;
        end else if (take) begin
            if (half) begin
                half <= 1'b0;
            end else begin
                half   <= 1'b1;
                held_a <= rnd_a;
                held_b <= rnd_b;
            end
        end
    end

    assert_anti_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_ready && rnd_valid) |=> (half && !rnd_ready));
    assert_anti_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && half) |=> !half);
    assert_take_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> avail);
endmodule

// File: rtl/mc_slot_ctr.sv
module mc_slot_ctr #(
    parameter int SLOTS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic last_slot
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    logic [CNT_W-1:0] cnt;

    assign last_slot = (cnt == CNT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(SLOTS));
    assert_no_inc_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(SLOTS)) |-> !inc);
endmodule

// File: rtl/mc_path_sched.sv
module mc_path_sched
    import mc_sched_pkg::*;
#(
    parameter int PRICE_W    = 32,
    parameter int VOL_W      = 32,
    parameter int RND_W      = 16,
    parameter int N_STEPS    = 64,
    parameter int STEP_W     = $clog2(N_STEPS + 1),
    parameter int SLOTS      = 64,
    parameter int INIT_PRICE = 100,
    parameter int INIT_VOL   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rnd_valid,
    output logic                    rnd_ready,
    input  logic signed [RND_W-1:0] rnd_a,
    input  logic signed [RND_W-1:0] rnd_b,
    output logic                    host_valid,
    input  logic                    host_ready,
    output logic [PRICE_W-1:0]      host_payoff,
    output logic                    iss_live,
    output logic                    iss_ok,
    output logic [STEP_W-1:0]       iss_step,
    output logic [PRICE_W-1:0]      iss_price,
    output logic [VOL_W-1:0]        iss_vol,
    output logic signed [RND_W-1:0] iss_rnd_a,
    output logic signed [RND_W-1:0] iss_rnd_b,
    input  logic                    fifo_valid,
    output logic                    fifo_pop,
    input  logic                    fifo_ok,
    input  logic [STEP_W-1:0]       fifo_step,
    input  logic [PRICE_W-1:0]      fifo_price,
    input  logic [VOL_W-1:0]        fifo_vol
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS);

    sched_state_t            state, state_nxt;
    sched_act_t              act;
    logic                    avail, take, last_slot, head_done;
    logic signed [RND_W-1:0] use_a, use_b;

    mc_anti_pair #(.RND_W(RND_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .take(take), .rnd_valid(rnd_valid),
        .rnd_a(rnd_a), .rnd_b(rnd_b), .avail(avail), .rnd_ready(rnd_ready),
        .use_a(use_a), .use_b(use_b)
    );

    mc_slot_ctr #(.SLOTS(SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .inc(act == ACT_CREATE), .last_slot(last_slot)
    );

    assign head_done = fifo_valid && (fifo_step == LAST_STEP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nxt;
    end

    // action choice and outputs
    always_comb begin
        act       = ACT_BUBBLE;
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (avail) begin
                    act = ACT_CREATE;
                    if (last_slot) state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (head_done) begin
                    if (avail && host_ready) act = ACT_RETIRE;
                end else if (fifo_valid && avail) begin
                    act = ACT_RECIRC;
                end
            end
            default: act = ACT_BUBBLE;
        endcase

        take        = (act != ACT_BUBBLE);
        fifo_pop    = (act == ACT_RECIRC) || (act == ACT_RETIRE);
        host_valid  = (state == ST_RUN) && head_done && avail;
        host_payoff = fifo_ok ? fifo_price : '0;

        iss_live  = take;
        iss_ok    = 1'b0;
        iss_step  = '0;
        iss_price = '0;
        iss_vol   = '0;
        iss_rnd_a = take ? use_a : '0;
        iss_rnd_b = take ? use_b : '0;
        if (act == ACT_RECIRC) begin
            iss_ok    = fifo_ok;
            iss_step  = fifo_step;
            iss_price = fifo_price;
            iss_vol   = fifo_vol;
        end else if (take) begin
            iss_ok    = 1'b1;
            iss_price = PRICE_W'(INIT_PRICE);
            iss_vol   = VOL_W'(INIT_VOL);
        end
    end

    assert_no_pop_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !fifo_pop);
    assert_pop_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> iss_live);
    assert_retire_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |-> (fifo_pop && iss_live && iss_step == '0));
    assert_host_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_ready && rnd_valid) |=> (host_valid && $stable(host_payoff)));
    assert_empty_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !fifo_valid) |-> (!iss_live && !fifo_pop));
    assert_bubble_no_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_live |-> !(host_valid && host_ready));
endmodule

// File: tb/mc_path_sched_test.sv
module mc_path_sched_test;
    localparam int PW = 12, VW = 8, RW = 8, NS = 3, SW = 2, SL = 6;
    localparam int LAT = 4, DEPTH = 8, BARRIER = 130;
    localparam int PHASE_CYC = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rnd_valid = 1'b0, rnd_ready, host_valid, host_ready = 1'b0;
    logic signed [RW-1:0] rnd_a = '0, rnd_b = '0, iss_rnd_a, iss_rnd_b;
    logic [PW-1:0] host_payoff, iss_price, fifo_price;
    logic iss_live, iss_ok, fifo_valid, fifo_pop, fifo_ok;
    logic [SW-1:0] iss_step, fifo_step;
    logic [VW-1:0] iss_vol, fifo_vol;

    always #5 clk = ~clk;

    mc_path_sched #(.PRICE_W(PW), .VOL_W(VW), .RND_W(RW), .N_STEPS(NS), .STEP_W(SW),
                    .SLOTS(SL), .INIT_PRICE(100), .INIT_VOL(4)) uut (
        .clk(clk), .rst_n(rst_n), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
        .rnd_a(rnd_a), .rnd_b(rnd_b), .host_valid(host_valid), .host_ready(host_ready),
        .host_payoff(host_payoff), .iss_live(iss_live), .iss_ok(iss_ok),
        .iss_step(iss_step), .iss_price(iss_price), .iss_vol(iss_vol),
        .iss_rnd_a(iss_rnd_a), .iss_rnd_b(iss_rnd_b), .fifo_valid(fifo_valid),
        .fifo_pop(fifo_pop), .fifo_ok(fifo_ok), .fifo_step(fifo_step),
        .fifo_price(fifo_price), .fifo_vol(fifo_vol)
    );

    // stand-in pipeline: step+1, price += rnd_a, knock out at barrier
    logic          p_live [LAT];
    logic          p_ok   [LAT];
    logic [SW-1:0] p_step [LAT];
    logic [PW-1:0] p_price[LAT];
    logic [VW-1:0] p_vol  [LAT];
    logic signed [RW-1:0] p_ra[LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) p_live[i] <= 1'b0;
        end else begin
            p_live[0] <= iss_live; p_ok[0] <= iss_ok; p_step[0] <= iss_step;
            p_price[0] <= iss_price; p_vol[0] <= iss_vol; p_ra[0] <= iss_rnd_a;
            for (int i = 1; i < LAT; i++) begin
                p_live[i] <= p_live[i-1]; p_ok[i] <= p_ok[i-1]; p_step[i] <= p_step[i-1];
                p_price[i] <= p_price[i-1]; p_vol[i] <= p_vol[i-1]; p_ra[i] <= p_ra[i-1];
            end
        end
    end
    logic [PW-1:0] out_price;
    assign out_price = p_price[LAT-1] + {{(PW-RW){p_ra[LAT-1][RW-1]}}, p_ra[LAT-1]};

    // FIFO model holding live packets only
    logic          f_ok   [DEPTH];
    logic [SW-1:0] f_step [DEPTH];
    logic [PW-1:0] f_price[DEPTH];
    logic [VW-1:0] f_vol  [DEPTH];
    int f_rd, f_wr, f_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            f_rd <= 0; f_wr <= 0; f_cnt <= 0;
        end else begin
            if (p_live[LAT-1]) begin
                f_ok[f_wr]    <= p_ok[LAT-1] && (out_price < PW'(BARRIER));
                f_step[f_wr]  <= p_step[LAT-1] + 1'b1;
                f_price[f_wr] <= out_price;
                f_vol[f_wr]   <= p_vol[LAT-1];
                f_wr <= (f_wr + 1) % DEPTH;
            end
            if (fifo_pop) f_rd <= (f_rd + 1) % DEPTH;
            f_cnt <= f_cnt + (p_live[LAT-1] ? 1 : 0) - (fifo_pop ? 1 : 0);
        end
    end
    assign fifo_valid = (f_cnt != 0);
    assign fifo_ok    = f_ok[f_rd];
    assign fifo_step  = f_step[f_rd];
    assign fifo_price = f_price[f_rd];
    assign fifo_vol   = f_vol[f_rd];

    int compared = 0, mismatched = 0;
    task automatic chk(input logic ok, input string tag, input longint act_v, input longint exp_v);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // bench model of requirements
    int  created_exp = 0, phase = 0, cycles = 0, retires = 0, zero_pay = 0, pos_pay = 0;
    logic exp_half = 1'b0, rnd_taken = 1'b0, checking = 1'b0;
    logic signed [RW-1:0] held_a = '0, held_b = '0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        if (checking) begin
            logic rnd_av, e_live, e_pop, e_hv, e_new, e_rec;
            logic signed [RW-1:0] ea, eb;
            rnd_av = exp_half || rnd_valid;
            e_new = 1'b0; e_rec = 1'b0; e_pop = 1'b0; e_hv = 1'b0;
            if (created_exp < SL) begin
                e_new = rnd_av;                                  // R3
            end else if (fifo_valid) begin
                if (fifo_step == SW'(NS)) begin
                    e_hv = rnd_av;                               // R6
                    if (rnd_av && host_ready) begin e_new = 1'b1; e_pop = 1'b1; end
                end else if (rnd_av) begin
                    e_rec = 1'b1; e_pop = 1'b1;                  // R5
                end
            end
            e_live = e_new || e_rec;
            ea = exp_half ? -held_a : rnd_a;
            eb = exp_half ? -held_b : rnd_b;
            chk(iss_live == e_live, e_live ? "R2 live issue" : "R8 bubble issue", iss_live, e_live);
            chk(fifo_pop == e_pop, created_exp < SL ? "R3 no pop in fill" : "R8 pop", fifo_pop, e_pop);
            chk(host_valid == e_hv, "R6 host_valid", host_valid, e_hv);
            if (e_hv)
                chk(host_payoff == (fifo_ok ? fifo_price : '0), "R6 payoff", host_payoff,
                    fifo_ok ? fifo_price : 0);
            chk(rnd_ready == (e_live && !exp_half), "R7 rnd_ready", rnd_ready, e_live && !exp_half);
            if (!e_live) begin
                chk({iss_ok, iss_step, iss_price, iss_vol, iss_rnd_a, iss_rnd_b} == '0,
                    "R2 bubble fields zero", {iss_ok, iss_step, iss_price, iss_vol}, 0);
                if (created_exp >= SL && !fifo_valid)
                    chk(!iss_live, "R10 empty bubble", iss_live, 0);
            end else begin
                chk(iss_rnd_a == ea && iss_rnd_b == eb, "R7 antithetic values",
                    {iss_rnd_a, iss_rnd_b}, {ea, eb});
                if (e_new)
                    chk(iss_step == 0 && iss_price == 100 && iss_vol == 4 && iss_ok,
                        "R3 new path fields", {iss_ok, iss_step, iss_price, iss_vol},
                        {1'b1, 2'd0, 12'd100, 8'd4});
                else
                    chk(iss_step == fifo_step && iss_price == fifo_price &&
                        iss_vol == fifo_vol && iss_ok == fifo_ok, "R5 recirculated fields",
                        {iss_ok, iss_step, iss_price, iss_vol},
                        {fifo_ok, fifo_step, fifo_price, fifo_vol});
            end
            if (e_hv && host_ready) begin
                retires++;
                if (fifo_ok) pos_pay++; else zero_pay++;
            end
            rnd_taken = e_live && !exp_half;
            if (e_live) begin
                if (exp_half) exp_half = 1'b0;
                else begin exp_half = 1'b1; held_a = rnd_a; held_b = rnd_b; end
            end
            if (e_new && created_exp < SL) created_exp++;
            cycles++;
            if (cycles > 20000) begin
                chk(1'b0, "watchdog", cycles, 20000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    // stimulus driver: inputs change 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (checking) begin
            if (rnd_taken || !rnd_valid) begin
                case (phase)
                    0, 2:    rnd_valid = 1'b1;
                    1:       rnd_valid = lfsr[3];
                    default: rnd_valid = lfsr[3] & lfsr[7];
                endcase
                rnd_a = RW'(int'(lfsr[7:0] % 61) - 30);
                rnd_b = RW'(int'(lfsr[15:8] % 21) - 10);
            end
            host_ready = (phase < 2) ? 1'b1 : lfsr[5];
            rnd_taken = 1'b0;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #3;
        // R1: reset state with no random pair offered
        chk(!iss_live && !fifo_pop && !host_valid && !rnd_ready, "R1 reset outputs",
            {iss_live, fifo_pop, host_valid, rnd_ready}, 0);
        checking = 1'b1;
        for (int p = 0; p < 4; p++) begin
            phase = p;
            repeat (PHASE_CYC) @(posedge clk);
        end
        #3;
        checking = 1'b0;
        chk(created_exp == SL, "R4 fill count", created_exp, SL);
        chk(retires > 50, "R6 retire count", retires, 51);
        chk(zero_pay > 0, "R6 knocked-out zero payoff seen", zero_pay, 1);
        chk(pos_pay > 0, "R6 surviving payoff seen", pos_pay, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule